// File: doc/BRIEF.md
# Manchester Bit Clock Recovery

This block takes a demodulated, oversampled data line carrying Manchester or bi-phase coded bits and recovers a bit clock to go with it. A clock-enable input, divided by a programmable factor, forms the timing tick. A saturating counter measures the number of ticks between successive transitions of the line. Each measured interval is sorted into a half-bit interval (1T), a full-bit interval (2T) or an illegal interval, using two programmable windows.

A start strobe from the bit-check supervisor arms the block. The block then skips the run of preamble ones. It locks on the first full-bit interval that ends in a falling transition, which is the zero start bit. From then on it follows the bit phase and emits one clock pulse per decoded bit, with the bit value on a data output. A timing violation, a coding violation or a silent line drops the block back to idle. It then raises a sticky error flag that tells the supervisor to resume bit checking.

Top module: `mcr_clock_recovery`

## Requirements
- R1: After reset, dclk_o, dout_o and err_o are 0 and the block ignores the line until start_i is pulsed.
- R2: One tick occurs per xlim_i pulses of ce_i (a value of 0 acts as 1), and every interval, limit and pulse length is counted in ticks.
- R3: An interval of n ticks between transitions is a half-bit if lim_min_i <= n <= lim_max_i, otherwise a full bit if lim_min_2t_i <= n <= lim_max_2t_i, otherwise illegal.
- R4: A start_i pulse clears err_o, stops any clock pulse and enters the synchronising state; the first transition seen afterwards only marks a time reference.
- R5: While synchronising, half-bit intervals (preamble) give no clock; the first full-bit interval ending in a falling transition is the start bit and gives a clock pulse with dout_o = 0.
- R6: After the start bit the block tracks phase: from a mid-bit transition a half-bit interval reaches a bit boundary with no clock, and a full-bit interval is the next mid-bit transition; from a boundary a half-bit interval is the next mid-bit transition. Each mid-bit transition yields one bit equal to the line level after it (rising = 1, falling = 0).
- R7: With xlim_i = 1, a bit's clock pulse rises in the clock cycle after the one in which its transition is sampled, lasts pulse_len_i ticks, and dout_o changes only as a pulse starts.
- R8: An illegal interval sets err_o, forces dclk_o low and returns the block to idle.
- R9: A full-bit interval that starts at a bit boundary, or a full-bit interval ending in a rising transition while synchronising, is a coding violation with the same effect as R8.
- R10: Once armed, when the tick count since the last transition exceeds lim_max_2t_i without a new transition, the block raises the error of R8; with xlim_i = 1 err_o rises 21 cycles after the transition for lim_max_2t_i = 19.
- R11: The interval counter saturates at its all-ones value, so a gap longer than the counter range is measured as the maximum count and never wraps.
- R12: In idle, transitions on din_i produce no clock pulse and leave err_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Basic timing clock enable |
| xlim_i | input | XW | Tick prescale factor for the baud range |
| din_i | input | 1 | Sampled demodulated data line |
| start_i | input | 1 | Start strobe from the bit-check supervisor |
| lim_min_i | input | CW | Lower bound of the half-bit window, ticks |
| lim_max_i | input | CW | Upper bound of the half-bit window, ticks |
| lim_min_2t_i | input | CW | Lower bound of the full-bit window, ticks |
| lim_max_2t_i | input | CW | Upper bound of the full-bit window, ticks |
| pulse_len_i | input | CW | Clock pulse width, ticks |
| dclk_o | output | 1 | Recovered bit clock |
| dout_o | output | 1 | Decoded bit value |
| err_o | output | 1 | Sticky timing or coding error flag |

## Verification
The assertions check, on every cycle, that the interval counter never wraps, that ticks are spaced by the prescale factor, and that each clock pulse is started by a decode decision. They also check that the decoded bit changes only as a pulse begins, that an error never shows together with a live clock, and that the error flag clears only on a start strobe. Only the bench scenarios show the decoding itself. These cover preamble skipping, start-bit lock, phase tracking over random payloads with jitter, the exact cycle in which the gap error fires, and the saturated measurement of an over-long gap. They also cover the divided tick rate and the silence in idle after a timing or coding error.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_RUN  = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        IV_BAD  = 2'd0,
        IV_HALF = 2'd1,
        IV_FULL = 2'd2
    } iv_class_e;
endpackage

// File: rtl/mcr_prescale.sv
module mcr_prescale #(
    parameter int XW = 3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          ce_i,
    input  logic [XW-1:0] xlim_i,
    output logic          tick_o
);
    logic [XW-1:0] pre_d, pre_q;
    logic [XW-1:0] top;

    always_comb begin
        top    = (xlim_i == '0) ? '0 : xlim_i - 1'b1;
        tick_o = ce_i && (pre_q >= top);
        pre_d  = pre_q;
        if (ce_i) begin
            pre_d = tick_o ? '0 : pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pre_q <= '0;
        else         pre_q <= pre_d;
    end

    // R2: with a factor above one, two ticks never fall in adjacent cycles
    p_tick_spacing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && xlim_i > 1) |=> (!tick_o || xlim_i <= 1));
endmodule

// File: rtl/mcr_interval.sv
module mcr_interval
    import mcr_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          din_i,
    input  logic [CW-1:0] lim_min_i,
    input  logic [CW-1:0] lim_max_i,
    input  logic [CW-1:0] lim_min_2t_i,
    input  logic [CW-1:0] lim_max_2t_i,
    output logic          edge_o,
    output iv_class_e     cls_o,
    output logic          gap_o
);
    localparam logic [CW-1:0] CNT_MAX = '1;
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } iv_t;

    iv_t  d, q;
    logic in_half, in_full;

    always_comb begin
        edge_o  = tick_i && (din_i != q.lvl);
        in_half = (q.cnt >= lim_min_i) && (q.cnt <= lim_max_i);
        in_full = (q.cnt >= lim_min_2t_i) && (q.cnt <= lim_max_2t_i);
        if (in_half)      cls_o = IV_HALF;
        else if (in_full) cls_o = IV_FULL;
        else              cls_o = IV_BAD;
        gap_o = tick_i && !edge_o && (q.cnt > lim_max_2t_i);

        d = q;
        if (tick_i) begin
            d.lvl = din_i;
            if (edge_o)               d.cnt = CNT_ONE;
            else if (q.cnt != CNT_MAX) d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{lvl: 1'b0, cnt: '0};
        else         q <= d;
    end

    // R11: a full counter stays full while the line is quiet
    p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !edge_o && q.cnt == CNT_MAX) |=> (q.cnt == CNT_MAX));
endmodule

// File: rtl/mcr_pulse.sv
module mcr_pulse #(
    parameter int CW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          fire_i,
    input  logic          kill_i,
    input  logic [CW-1:0] len_i,
    output logic          dclk_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        dclk_o = (cnt_q != '0);
        cnt_d  = cnt_q;
        if (kill_i)                     cnt_d = '0;
        else if (fire_i)                cnt_d = len_i;
        else if (tick_i && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // R7: a pulse only begins after a decode decision
    p_pulse_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(dclk_o) |-> $past(fire_i));
endmodule

// File: rtl/mcr_clock_recovery.sv
module mcr_clock_recovery
    import mcr_pkg::*;
#(
    parameter int CW = 8,
    parameter int XW = 3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          ce_i,
    input  logic [XW-1:0] xlim_i,
    input  logic          din_i,
    input  logic          start_i,
    input  logic [CW-1:0] lim_min_i,
    input  logic [CW-1:0] lim_max_i,
    input  logic [CW-1:0] lim_min_2t_i,
    input  logic [CW-1:0] lim_max_2t_i,
    input  logic [CW-1:0] pulse_len_i,
    output logic          dclk_o,
    output logic          dout_o,
    output logic          err_o
);
    typedef struct packed {
        rx_state_e st;
        logic      armed;
        logic      mid;
        logic      dout;
        logic      err;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, armed: 1'b0, mid: 1'b0, dout: 1'b0, err: 1'b0};

    ctl_t      d, q;
    logic      tick, edge_s, gap;
    iv_class_e cls;
    logic      fire, kill, fault;

    mcr_prescale #(.XW(XW)) u_pre (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .ce_i  (ce_i),
        .xlim_i(xlim_i),
        .tick_o(tick)
    );

    mcr_interval #(.CW(CW)) u_iv (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick),
        .din_i       (din_i),
        .lim_min_i   (lim_min_i),
        .lim_max_i   (lim_max_i),
        .lim_min_2t_i(lim_min_2t_i),
        .lim_max_2t_i(lim_max_2t_i),
        .edge_o      (edge_s),
        .cls_o       (cls),
        .gap_o       (gap)
    );

    mcr_pulse #(.CW(CW)) u_pulse (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tick_i(tick),
        .fire_i(fire),
        .kill_i(kill),
        .len_i (pulse_len_i),
        .dclk_o(dclk_o)
    );

    always_comb begin
        d     = q;
        fire  = 1'b0;
        fault = 1'b0;
        if (start_i) begin
            d.st    = ST_SYNC;
            d.armed = 1'b0;
            d.mid   = 1'b1;
            d.err   = 1'b0;
        end else begin
            unique case (q.st)
                ST_SYNC: begin
                    if (edge_s) begin
                        if (!q.armed) begin
                            d.armed = 1'b1;
                        end else if (cls == IV_FULL) begin
                            if (!din_i) begin
                                d.st   = ST_RUN;
                                d.mid  = 1'b1;
                                d.dout = 1'b0;
                                fire   = 1'b1;
                            end else begin
                                fault = 1'b1;
                            end
                        end else if (cls == IV_BAD) begin
                            fault = 1'b1;
                        end
                    end else if (gap && q.armed) begin
                        fault = 1'b1;
                    end
                end
                ST_RUN: begin
                    if (edge_s) begin
                        if (cls == IV_HALF) begin
                            d.mid = !q.mid;
                            if (!q.mid) begin
                                d.dout = din_i;
                                fire   = 1'b1;
                            end
                        end else if (cls == IV_FULL && q.mid) begin
                            d.dout = din_i;
                            fire   = 1'b1;
                        end else begin
                            fault = 1'b1;
                        end
                    end else if (gap) begin
                        fault = 1'b1;
                    end
                end
                default: ;
            endcase
            if (fault) begin
                d.st  = ST_IDLE;
                d.err = 1'b1;
                fire  = 1'b0;
            end
        end
        kill = start_i || fault;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= CTL_RST;
        else         q <= d;
    end

    assign dout_o = q.dout;
    assign err_o  = q.err;

    // R8: the error never appears with a running clock pulse
    p_err_no_clock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_o) |-> !dclk_o);

    // R4: the error flag only clears on a start strobe
    p_err_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(err_o) |-> $past(start_i));

    // R7: the decoded bit moves only as a clock pulse begins
    p_dout_with_clock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$stable(dout_o) && $past(pulse_len_i) != '0) |-> dclk_o);

    // R12: nothing is clocked out while idle
    p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_IDLE) |=> !dclk_o);
endmodule

// File: tb/mcr_clock_recovery_test.sv
module mcr_clock_recovery_test;
    typedef bit bitq_t[$];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce = 1'b1;
    logic [2:0] xlim = 3'd1;
    logic       din = 1'b1;
    logic       start = 1'b0;
    logic [7:0] lmin = 8'd6, lmax = 8'd10, lmin2 = 8'd13, lmax2 = 8'd19;
    logic [7:0] plen = 8'd3;
    logic       dclk, dout, err;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    int  chg_cyc = 0;
    bit  chk_delay = 1'b1;
    int  exp_w = 3;
    bit  exp_q[$];
    bit  done = 1'b0;

    mcr_clock_recovery #(.CW(8), .XW(3)) uut (
        .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .xlim_i(xlim), .din_i(din),
        .start_i(start), .lim_min_i(lmin), .lim_max_i(lmax),
        .lim_min_2t_i(lmin2), .lim_max_2t_i(lmax2), .pulse_len_i(plen),
        .dclk_o(dclk), .dout_o(dout), .err_o(err)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // bench model: half-bit levels of a frame; bit b is sent as (~b, b)
    function automatic bitq_t halves(int npre, bitq_t pl);
        bitq_t lv;
        for (int i = 0; i < npre; i++) begin lv.push_back(1'b0); lv.push_back(1'b1); end
        lv.push_back(1'b1); lv.push_back(1'b0);
        foreach (pl[i]) begin lv.push_back(!pl[i]); lv.push_back(pl[i]); end
        return lv;
    endfunction

    function automatic int jit(int j);
        if (j == 0) return 0;
        return int'($urandom_range(2 * j)) - j;
    endfunction

    // clock pulse monitor: R5/R6 bit values, R7 delay and width
    bit prev_dclk = 1'b0;
    int width = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (dclk && !prev_dclk) begin
                width = 1;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6/R12 unexpected clock", 1, 0);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    check(dout == e, "R6 bit value", int'(dout), int'(e));
                end
                if (chk_delay) check(cyc == chg_cyc + 1, "R7 delay", cyc - chg_cyc, 1);
            end else if (dclk) begin
                width++;
            end else if (prev_dclk) begin
                check(width == exp_w, "R7 width", width, exp_w);
            end
        end
        prev_dclk = dclk;
    end

    task automatic drive(bit lvl, int hold);
        din = lvl;
        chg_cyc = cyc;
        repeat (hold) @(negedge clk);
    endtask

    task automatic toggle(int hold);
        drive(!din, hold);
    endtask

    task automatic begin_frame();
        din = 1'b1;
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(err == 1'b0, "R4 start clears error", int'(err), 0);
    endtask

    task automatic send_frame(int npre, bitq_t pl, int unit, int j);
        bitq_t lv;
        int i;
        lv = halves(npre, pl);
        exp_q.push_back(1'b0);
        foreach (pl[k]) exp_q.push_back(pl[k]);
        i = 0;
        while (i < lv.size()) begin
            int r;
            r = 1;
            while (i + r < lv.size() && lv[i + r] == lv[i]) r++;
            drive(lv[i], r * unit + jit(r == 1 ? j : (j == 0 ? 0 : j + 1)));
            i += r;
        end
    endtask

    task automatic end_frame(string req);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        bitq_t pl;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset values
        check(dclk == 1'b0 && dout == 1'b0 && err == 1'b0, "R1 reset outputs",
              {dclk, dout, err}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1/R12: line activity before any start strobe is ignored
        repeat (4) toggle(8);
        check(err == 1'b0, "R1 idle before start", int'(err), 0);

        // R5/R6/R7: directed frame, exact timing, then R10 gap at 21 cycles
        begin_frame();
        pl = '{1, 0, 0, 1, 1, 1, 0, 1};
        send_frame(5, pl, 8, 0);
        repeat (12) @(negedge clk);
        check(err == 1'b0, "R10 no gap error at 20 cycles", int'(err), 0);
        @(negedge clk);
        check(err == 1'b1, "R10 gap error at 21 cycles", int'(err), 1);
        end_frame("R5 all bits clocked");

        // R3/R6: random payloads with edge jitter across both windows
        for (int f = 0; f < 4; f++) begin
            pl.delete();
            for (int b = 0; b < 10 + int'($urandom_range(8)); b++) pl.push_back(bit'($urandom_range(1)));
            begin_frame();
            send_frame(3 + int'($urandom_range(4)), pl, 8, 2);
            repeat (40) @(negedge clk);
            check(err == 1'b1, "R10 frame end error", int'(err), 1);
            end_frame("R3 random frame bits");
        end

        // R8: a half-bit stretched beyond lim_max is a timing error
        begin_frame();
        pl = '{1, 0};
        send_frame(4, pl, 8, 0);
        toggle(11);
        toggle(8);
        check(err == 1'b1, "R8 timing error flag", int'(err), 1);
        check(dclk == 1'b0, "R8 clock stopped", int'(dclk), 0);
        end_frame("R8 bits before error");
        // R12: edges in idle give no clock and keep the error
        repeat (6) toggle(16);
        check(err == 1'b1, "R12 error held in idle", int'(err), 1);

        // R9: full-bit interval starting at a boundary
        begin_frame();
        pl = '{1, 1};
        send_frame(4, pl, 8, 0);
        toggle(8);
        repeat (8) @(negedge clk);
        toggle(8);
        check(err == 1'b1, "R9 code violation", int'(err), 1);
        end_frame("R9 bits before violation");

        // R9: full-bit interval ending rising while synchronising
        begin_frame();
        toggle(8);
        toggle(8);
        toggle(16);
        toggle(8);
        check(err == 1'b1, "R9 bad start bit", int'(err), 1);
        end_frame("R9 no clock in sync");

        // R11: a 264-tick gap is read as 255 (full bit), not 8 (half bit)
        lmax2 = 8'd255;
        begin_frame();
        pl.delete();
        send_frame(4, pl, 8, 0);
        repeat (256) @(negedge clk);
        exp_q.push_back(1'b1);
        toggle(8);
        check(err == 1'b0, "R11 saturated gap accepted", int'(err), 0);
        end_frame("R11 saturated bit clocked");
        lmax2 = 8'd19;

        // R2: divided tick, every interval in cycles doubles
        xlim = 3'd2;
        exp_w = 6;
        chk_delay = 1'b0;
        begin_frame();
        pl = '{0, 1, 1, 0, 1, 0, 0, 0};
        send_frame(4, pl, 16, 0);
        repeat (80) @(negedge clk);
        check(err == 1'b1, "R2 frame end error", int'(err), 1);
        end_frame("R2 bits at divided tick");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule